// File: doc/BRIEF.md
# Chainable Serial Channel Control and Fault Readback Port

This block is the digital control port of a small bank of low-side switches. A host writes one command bit per channel through a serial clock and data pair. A separate strobe then moves the collected bits into the register that drives the switches. The same shift chain carries per-channel fault flags back to the host. The serial output of each block feeds the serial input of the next, so any number of blocks can share one host port and behave as one long shift register.

All external pins are asynchronous. They are brought into the system clock through multi-stage synchronisers. Edges of the serial clock and of the strobe are found from the synchronised samples. Writing uses rising serial-clock edges while the strobe is low. Reading starts once the strobe has stayed high for a minimum number of system clocks. After that, the first falling serial-clock edge loads the fault flags into the chain, and each later falling edge moves the chain one step toward the serial output. An active-low drive-enable pin gates the switch outputs and nothing else. An active-high clear pin, or the power-up reset, empties every register of the port.

Top module: `serial_lowside_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `chan_on_o` is all zero and `ser_dout_o` is 0.
- R2: While the synchronised strobe is low, each rising serial-clock edge shifts `ser_din_i` into the chain at bit 0 and moves every bit one place up. Bit n-1 drives channel n, so after NUM_CH shifts the first bit sent sits in the top bit (channel NUM_CH) and the last bit sent sits in bit 0 (channel 1).
- R3: A rising strobe edge copies the chain into the output register. The output register keeps its value at all other times, including while bits are being shifted.
- R4: `ser_dout_o` always shows the top bit of the chain. Two blocks with the first one's `ser_dout_o` driving the second one's `ser_din_i` act as one 2*NUM_CH-bit register. Of eight bits sent top bit first, the first four land in the second block.
- R5: Once the strobe has been high for at least LATCH_MIN_CLKS system clocks, the first falling serial-clock edge loads `fault_i` into the chain, with bit n-1 holding channel n. `ser_dout_o` then shows the channel-NUM_CH fault. Each later falling edge shifts the chain once. For two chained blocks, the host sees the second block's faults from its channel 4 down to 1, then the first block's faults in the same order.
- R6: A falling serial-clock edge that comes before the strobe has been high for LATCH_MIN_CLKS clocks neither loads nor shifts the chain.
- R7: A rising serial-clock edge while the strobe is high, and a falling edge while the strobe is low, leave the chain unchanged.
- R8: While `drv_en_n_i` is high, `chan_on_o` is zero. While it is low, `chan_on_o` equals the output register. The pin does not change the stored bits, shifting or readback.
- R9: A high level on `ser_clr_i` clears the chain, the output register and the readback state, so `chan_on_o` and `ser_dout_o` go to 0.
- R10: When the strobe and the serial clock rise in the same system clock, the output register takes the chain contents from before that edge, and that serial-clock edge shifts nothing.
- R11: A strobe change on the pin reaches `chan_on_o` on the (SYNC_STAGES+1)-th rising system-clock edge after it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| ser_clk_i | input | 1 | Serial clock pin |
| ser_din_i | input | 1 | Serial data input pin |
| ser_latch_i | input | 1 | Strobe pin: rising edge applies written bits and starts a fault read |
| ser_clr_i | input | 1 | Serial port clear, active high |
| drv_en_n_i | input | 1 | Drive enable, active low |
| fault_i | input | NUM_CH | Per-channel fault flags, bit n-1 for channel n |
| ser_dout_o | output | 1 | Serial data output, top bit of the chain |
| chan_on_o | output | NUM_CH | Channel drive, gated by the enable |

## Verification
The strobe rising edge and a serial-clock rising edge can land in the same synchronised cycle. The bench forces this by driving both pins high at the same moment, after writing a known word. It then checks that the channels show that word and that the serial output has not moved, which shows the clock edge was not taken as a shift. It also places a falling serial-clock edge a few clocks after the strobe rises, inside the hold window. That edge must leave the serial output as it was, and a later falling edge must load the fault flags.

// File: rtl/slc_pkg.sv
package slc_pkg;
   // positions of the pins inside the synchroniser bank
   localparam int unsigned PIX_SCLK  = 0;
   localparam int unsigned PIX_SDI   = 1;
   localparam int unsigned PIX_LATCH = 2;
   localparam int unsigned PIX_CLR   = 3;
   localparam int unsigned PIX_ENN   = 4;
   localparam int unsigned PIN_COUNT = 5;

   // operation applied to the shift chain in one system clock
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_SHIFT = 2'd1,
      OP_LOAD  = 2'd2,
      OP_CLEAR = 2'd3
   } slc_op_e;
endpackage

// File: rtl/slc_sync_bank.sv
module slc_sync_bank #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] lvl_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("slc_sync_bank: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("slc_sync_bank: WIDTH must be at least 1");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_bit
         logic [STAGES-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[STAGES-2:0], raw_i[gi]};
         end
         assign lvl_o[gi] = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/slc_shift_chain.sv
module slc_shift_chain
   import slc_pkg::*;
#(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  slc_op_e      op_i,
   input  logic         din_i,
   input  logic [N-1:0] par_i,
   output logic [N-1:0] q_o
);
   generate
      if (N < 2) begin : g_bad_n
         $error("slc_shift_chain: N must be at least 2");
      end
   endgenerate

   logic [N-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         case (op_i)
            OP_CLEAR: chain_q <= '0;
            OP_LOAD:  chain_q <= par_i;
            OP_SHIFT: chain_q <= {chain_q[N-2:0], din_i};
            default:  chain_q <= chain_q;
         endcase
      end
   end

   assign q_o = chain_q;
endmodule

// File: rtl/slc_read_window.sv
module slc_read_window #(
   parameter int unsigned MIN_CLKS = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic latch_lvl_i,
   input  logic sclk_fall_i,
   output logic load_o,
   output logic shift_o
);
   generate
      if (MIN_CLKS < 1) begin : g_bad_min
         $error("slc_read_window: MIN_CLKS must be at least 1");
      end
   endgenerate

   localparam int unsigned CW = $clog2(MIN_CLKS + 1);
   localparam logic [CW-1:0] CNT_TOP = CW'(MIN_CLKS);

   logic [CW-1:0] hold_cnt;
   logic          loaded_q;
   logic          open_w;
   logic          take_w;

   assign open_w = (hold_cnt == CNT_TOP);
   assign take_w = latch_lvl_i & sclk_fall_i & open_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_cnt <= '0;
         loaded_q <= 1'b0;
      end else if (clr_i || !latch_lvl_i) begin
         hold_cnt <= '0;
         loaded_q <= 1'b0;
      end else begin
         if (!open_w) hold_cnt <= hold_cnt + 1'b1;
         if (take_w)  loaded_q <= 1'b1;
      end
   end

   assign load_o  = take_w & ~loaded_q;
   assign shift_o = take_w &  loaded_q;
endmodule

// File: rtl/slc_out_stage.sv
module slc_out_stage #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         cap_i,
   input  logic [N-1:0] d_i,
   input  logic         en_n_i,
   output logic [N-1:0] q_o,
   output logic [N-1:0] drive_o
);
   logic [N-1:0] out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     out_q <= '0;
      else if (clr_i) out_q <= '0;
      else if (cap_i) out_q <= d_i;
   end

   genvar gc;
   generate
      for (gc = 0; gc < N; gc++) begin : g_gate
         assign drive_o[gc] = out_q[gc] & ~en_n_i;
      end
   endgenerate

   assign q_o = out_q;
endmodule

// File: rtl/serial_lowside_ctrl.sv
module serial_lowside_ctrl
   import slc_pkg::*;
#(
   parameter int unsigned NUM_CH         = 4,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned LATCH_MIN_CLKS = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk_i,
   input  logic              ser_din_i,
   input  logic              ser_latch_i,
   input  logic              ser_clr_i,
   input  logic              drv_en_n_i,
   input  logic [NUM_CH-1:0] fault_i,
   output logic              ser_dout_o,
   output logic [NUM_CH-1:0] chan_on_o
);
   generate
      if (NUM_CH < 2) begin : g_bad_ch
         $error("serial_lowside_ctrl: NUM_CH must be at least 2");
      end
   endgenerate

   logic [PIN_COUNT-1:0] pin_raw;
   logic [PIN_COUNT-1:0] pin_lvl;

   assign pin_raw[PIX_SCLK]  = ser_clk_i;
   assign pin_raw[PIX_SDI]   = ser_din_i;
   assign pin_raw[PIX_LATCH] = ser_latch_i;
   assign pin_raw[PIX_CLR]   = ser_clr_i;
   assign pin_raw[PIX_ENN]   = drv_en_n_i;

   slc_sync_bank #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (pin_raw),
      .lvl_o (pin_lvl)
   );

   logic sclk_lvl, latch_lvl, clr_lvl;
   logic sclk_prv, latch_prv;
   logic sclk_rise, sclk_fall, latch_rise;

   assign sclk_lvl  = pin_lvl[PIX_SCLK];
   assign latch_lvl = pin_lvl[PIX_LATCH];
   assign clr_lvl   = pin_lvl[PIX_CLR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prv  <= 1'b0;
         latch_prv <= 1'b0;
      end else begin
         sclk_prv  <= sclk_lvl;
         latch_prv <= latch_lvl;
      end
   end

   assign sclk_rise  =  sclk_lvl & ~sclk_prv;
   assign sclk_fall  = ~sclk_lvl &  sclk_prv;
   assign latch_rise =  latch_lvl & ~latch_prv;

   logic rd_load, rd_shift, wr_shift;

   slc_read_window #(.MIN_CLKS(LATCH_MIN_CLKS)) u_win (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (clr_lvl),
      .latch_lvl_i (latch_lvl),
      .sclk_fall_i (sclk_fall),
      .load_o      (rd_load),
      .shift_o     (rd_shift)
   );

   assign wr_shift = sclk_rise & ~latch_lvl;

   slc_op_e chain_op;
   always_comb begin
      if (clr_lvl)                    chain_op = OP_CLEAR;
      else if (rd_load)               chain_op = OP_LOAD;
      else if (wr_shift || rd_shift)  chain_op = OP_SHIFT;
      else                            chain_op = OP_HOLD;
   end

   logic [NUM_CH-1:0] chain_q;
   logic [NUM_CH-1:0] out_q;

   slc_shift_chain #(.N(NUM_CH)) u_chain (
      .clk   (clk),
      .rst_n (rst_n),
      .op_i  (chain_op),
      .din_i (pin_lvl[PIX_SDI]),
      .par_i (fault_i),
      .q_o   (chain_q)
   );

   slc_out_stage #(.N(NUM_CH)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr_lvl),
      .cap_i   (latch_rise),
      .d_i     (chain_q),
      .en_n_i  (pin_lvl[PIX_ENN]),
      .q_o     (out_q),
      .drive_o (chan_on_o)
   );

   assign ser_dout_o = chain_q[NUM_CH-1];
endmodule

// File: rtl/slc_chk.sv
module slc_chk #(
   parameter int unsigned N        = 4,
   parameter int unsigned MIN_CLKS = 20
) (
   input logic         clk,
   input logic         rst_n,
   input logic [4:0]   lvl,
   input logic         sclk_rise,
   input logic         sclk_fall,
   input logic         latch_rise,
   input logic [N-1:0] chain_q,
   input logic [N-1:0] out_q,
   input logic [N-1:0] chan_on_o,
   input logic [N-1:0] fault_i
);
   localparam int unsigned CW = $clog2(MIN_CLKS + 1);

   logic latch_l, clr_l, enn_l, sdi_l;
   assign sdi_l   = lvl[1];
   assign latch_l = lvl[2];
   assign clr_l   = lvl[3];
   assign enn_l   = lvl[4];

   // independent count of strobe-high cycles and of the first read edge
   logic [CW-1:0] seen_cnt;
   logic          seen_load;
   logic          win_ok;
   assign win_ok = (int'(seen_cnt) >= MIN_CLKS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_cnt  <= '0;
         seen_load <= 1'b0;
      end else if (clr_l || !latch_l) begin
         seen_cnt  <= '0;
         seen_load <= 1'b0;
      end else begin
         if (!win_ok) seen_cnt <= seen_cnt + 1'b1;
         if (sclk_fall && win_ok) seen_load <= 1'b1;
      end
   end

   a_r2_write_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_rise && !latch_l && !clr_l) |=> chain_q == {$past(chain_q[N-2:0]), $past(sdi_l)});

   a_r3_latch_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_rise && !clr_l) |=> out_q == $past(chain_q));

   a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_rise && !clr_l) |=> $stable(out_q));

   a_r5_fault_load: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_fall && latch_l && win_ok && !seen_load && !clr_l) |=> chain_q == $past(fault_i));

   a_r6_early_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_fall && latch_l && !win_ok && !clr_l) |=> $stable(chain_q));

   a_r7_wrong_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (((sclk_rise && latch_l) || (sclk_fall && !latch_l)) && !clr_l) |=> $stable(chain_q));

   a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
      enn_l |-> chan_on_o == '0);

   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_l |=> (chain_q == '0 && out_q == '0));

   a_r10_coincide: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_rise && sclk_rise && !clr_l) |=> (out_q == $past(chain_q) && $stable(chain_q)));
endmodule

bind serial_lowside_ctrl slc_chk #(.N(NUM_CH), .MIN_CLKS(LATCH_MIN_CLKS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lvl        (pin_lvl),
   .sclk_rise  (sclk_rise),
   .sclk_fall  (sclk_fall),
   .latch_rise (latch_rise),
   .chain_q    (chain_q),
   .out_q      (out_q),
   .chan_on_o  (chan_on_o),
   .fault_i    (fault_i)
);

// File: tb/sim_serial_lowside_ctrl.sv
`timescale 1ns/1ps
module sim_serial_lowside_ctrl;
   localparam int PH   = 6;   // system clocks per serial half period
   localparam int WAIT = 30;  // strobe hold before reading (> 20)

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, sdi = 1'b0, latch = 1'b0, sclr = 1'b0, enn = 1'b0;
   logic [3:0] f_a = '0, f_b = '0;
   logic dout_a, dout_b;
   logic [3:0] on_a, on_b;

   int n_chk = 0;
   int n_bad = 0;

   // bench model: hold = {B chain, A chain}, outr = {B out, A out}
   logic [7:0] hold = '0;
   logic [7:0] outr = '0;

   always #5 clk = ~clk;

   serial_lowside_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_din_i(sdi),
      .ser_latch_i(latch), .ser_clr_i(sclr), .drv_en_n_i(enn),
      .fault_i(f_a), .ser_dout_o(dout_a), .chan_on_o(on_a));

   serial_lowside_ctrl u1 (
      .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_din_i(dout_a),
      .ser_latch_i(latch), .ser_clr_i(sclr), .drv_en_n_i(enn),
      .fault_i(f_b), .ser_dout_o(dout_b), .chan_on_o(on_b));

   function automatic logic [7:0] shift8(input logic [7:0] h, input logic b);
      return {h[6:0], b};
   endfunction

   function automatic logic [7:0] drive8(input logic [7:0] o, input logic en_n);
      return en_n ? 8'h00 : o;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_word(input logic [7:0] w, input bit check_out);
      for (int i = 7; i >= 0; i--) begin
         sdi = w[i];
         settle(PH);
         sclk = 1'b1;
         settle(PH);
         hold = shift8(hold, w[i]);
         sclk = 1'b0;
         settle(PH);
         chk("R4 serial out follows top stage", dout_b, hold[7]);
      end
      if (check_out) chk("R3 outputs hold while shifting", {on_b, on_a}, drive8(outr, enn));
   endtask

   task automatic strobe_up();
      latch = 1'b1;
      settle(PH);
      outr = hold;
   endtask

   task automatic strobe_down();
      latch = 1'b0;
      settle(PH);
   endtask

   task automatic read_word(output logic [7:0] r);
      sdi = 1'b0;
      settle(WAIT);
      sclk = 1'b1;
      settle(PH);
      chk("R7 rise with strobe high ignored", dout_b, hold[7]);
      sclk = 1'b0;
      settle(PH);
      hold = {f_b, f_a};
      r[7] = dout_b;
      for (int i = 6; i >= 0; i--) begin
         sclk = 1'b1;
         settle(PH);
         sclk = 1'b0;
         settle(PH);
         hold = shift8(hold, 1'b0);
         r[i] = dout_b;
      end
   endtask

   initial begin
      #1_500_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] w, r, keep;
      int seed;
      seed = $urandom(32'h51C0_0DE5);

      settle(3);
      chk("R1 channels zero in reset", {on_b, on_a}, 0);
      chk("R1 serial out zero in reset", dout_b, 0);
      rst_n = 1'b1;
      settle(4);
      chk("R1 channels zero after reset", {on_b, on_a}, 0);
      chk("R1 serial out zero after reset", dout_b, 0);

      // R2 bit order: first bit sent lands on device B channel 4
      write_word(8'h81, 1'b1);
      strobe_up();
      strobe_down();
      chk("R2 device B gets first bit on ch4", on_b, 4'h8);
      chk("R2 device A gets last bit on ch1", on_a, 4'h1);

      // R11 latency of the strobe to the channels
      write_word(8'h5A, 1'b1);
      latch = 1'b1;
      settle(2);
      chk("R11 no change before sync delay", {on_b, on_a}, 8'h81);
      settle(1);
      chk("R11 change after sync delay", {on_b, on_a}, 8'h5A);
      outr = hold;
      settle(PH);
      strobe_down();

      // random transactions with enable and fault patterns
      for (int it = 0; it < 10; it++) begin
         w   = 8'($urandom);
         f_a = 4'($urandom);
         f_b = 4'($urandom);
         enn = 1'($urandom);
         write_word(w, 1'b1);
         strobe_up();
         chk("R3 strobe applies written word", {on_b, on_a}, drive8(w, enn));
         chk("R8 enable gating", {on_b, on_a}, drive8(outr, enn));
         read_word(r);
         chk("R5 fault readback order", r, {f_b, f_a});
         strobe_down();
         chk("R8 readback leaves outputs", {on_b, on_a}, drive8(outr, enn));
      end

      // R8 stored bits survive a disable
      enn = 1'b0;
      write_word(8'hC3, 1'b1);
      strobe_up();
      strobe_down();
      enn = 1'b1;
      settle(PH);
      chk("R8 disabled drive is zero", {on_b, on_a}, 0);
      enn = 1'b0;
      settle(PH);
      chk("R8 re-enable restores outputs", {on_b, on_a}, 8'hC3);

      // R6 early falling edge inside the hold window
      write_word(8'h0F, 1'b0);
      f_a = 4'h9;
      f_b = 4'hE;
      latch = 1'b1;
      outr = hold;
      settle(2);
      sclk = 1'b1;
      settle(3);
      sclk = 1'b0;
      settle(3);
      chk("R6 early fall does not load", dout_b, hold[7]);
      read_word(r);
      chk("R6 later fall loads faults", r, {f_b, f_a});
      strobe_down();

      // R10 strobe and serial clock rise together
      write_word(8'h96, 1'b0);
      keep = hold;
      sdi = 1'b1;
      settle(PH);
      latch = 1'b1;
      sclk  = 1'b1;
      settle(PH);
      outr = hold;
      chk("R10 outputs take pre-edge word", {on_b, on_a}, keep);
      chk("R10 coincident edge not shifted", dout_b, keep[7]);
      latch = 1'b0;
      settle(PH);
      sclk = 1'b0;
      settle(PH);
      chk("R7 fall with strobe low ignored", dout_b, keep[7]);
      chk("R7 outputs unchanged by fall", {on_b, on_a}, keep);

      // R9 serial clear empties everything
      sdi = 1'b0;
      write_word(8'hFF, 1'b0);
      sclr = 1'b1;
      settle(PH);
      sclr = 1'b0;
      settle(PH);
      hold = '0;
      outr = '0;
      chk("R9 clear zeroes channels", {on_b, on_a}, 0);
      chk("R9 clear zeroes serial out", dout_b, 0);
      strobe_up();
      strobe_down();
      chk("R9 cleared chain applies zero", {on_b, on_a}, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule